// File: doc/BRIEF.md
# Task Address Set Differencer

This block watches the memory accesses of one task instance, between a start strobe and a stop strobe. It builds the set of distinct addresses the instance touched, kept in the order each address was first seen. A later access to an address already held, whether a read or a write, adds nothing. The set has a fixed capacity. New addresses that arrive once it is full are dropped, and an overflow flag records the loss.

When the instance stops, the block compares its set with the one kept from the previous instance. It streams out the signed difference of each position pair, one element per cycle, marked with valid and last. When the two sets differ in length, only the common prefix is streamed and a mismatch flag is raised. The very first instance after reset has nothing to compare against, so it only becomes the reference.

Two storage banks alternate between the roles of current set and reference set. Each finished instance therefore becomes the reference for the next one without any copying.

Top module: `addr_set_diff`

## Requirements
- R1: Accesses are recorded only in cycles after a `taskStart` has been accepted and before `taskStop` is seen. An access in the same cycle as `taskStart` or `taskStop`, or while idle, has no effect on the set.
- R2: An access whose address is already in the current set is dropped, whether `accWrite` is 0 (read) or 1 (write).
- R3: Set entries are kept in the order of the first access to each address.
- R4: Element i of the output equals current address i minus previous address i. It is a two's-complement value of ADDR_W+1 bits and may be negative.
- R5: The first instance after reset produces no output elements. Its set becomes the reference.
- R6: Elements appear one per cycle with `diffValid` high on consecutive cycles, starting the cycle after `taskStop` is sampled. `diffLast` is high only on the final element.
- R7: A new address arriving while the set already holds CAP entries is dropped. `setOverflow` then goes to 1 and stays there until the next accepted `taskStart`.
- R8: If the two set lengths differ, only min(current, previous) elements are produced. `lenMismatch` is 1 from the cycle after `taskStop` until the next accepted `taskStart`. After the first instance it is always 0.
- R9: Each finished instance becomes the reference for the next one, across any number of instances.
- R10: A `taskStart` that arrives while the block is recording or streaming is ignored and does not clear the set being built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| taskStart | input | 1 | Task instance begins |
| taskStop | input | 1 | Task instance ends |
| accValid | input | 1 | Memory access present this cycle |
| accWrite | input | 1 | Access is a write (1) or a read (0) |
| accAddr | input | ADDR_W | Access address |
| diffValid | output | 1 | Differential element valid |
| diffLast | output | 1 | Final element of the vector |
| diffData | output | ADDR_W+1 | Signed difference, current minus previous |
| lenMismatch | output | 1 | Set lengths of the two instances differ |
| setOverflow | output | 1 | Addresses were dropped for lack of capacity |

## Verification
The main function is driven with the following patterns, each of which tells apart a specific fault:

- **Two equal-length sets giving positive strides.** This catches swapped operands, because a swap would turn every stride negative.
- **A set rebuilt with reads and writes repeated.** This shows whether duplicates are dropped and whether the first-access order survives.
- **A longer set.** This separates prefix-only streaming from streaming of stale entries.
- **Directed runs covering the remaining corners:**
  - accesses outside the recording window;
  - a start strobe arriving in mid-recording;
  - overflow past capacity;
  - an empty set;
  - a reset in mid-sequence, which must bring back the silent first instance.

// File: rtl/asd_pkg.sv
package asd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REC, ST_EMIT} asdState_t;

  typedef struct packed {
    logic clearCur;
    logic recEn;
    logic swapBanks;
  } dpCtl_t;
endpackage

// File: rtl/asd_dpath.sv
module asd_dpath
  import asd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CAP    = 8,
  parameter int CNT_W  = $clog2(CAP + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic [ADDR_W-1:0]   accAddr,
  input  logic [CNT_W-1:0]    rdIdx,
  output logic                hit,
  output logic                full,
  output logic [CNT_W-1:0]    curCnt,
  output logic [CNT_W-1:0]    refCnt,
  output logic signed [ADDR_W:0] diffData
);
  localparam int IDX_W = (CAP > 1) ? $clog2(CAP) : 1;

  logic [ADDR_W-1:0] bankMem [2][CAP];
  logic [CNT_W-1:0]  bankCnt [2];
  logic              curBank;
  logic [CAP-1:0]    hitVec;
  logic              doStore;

  assign curCnt = bankCnt[curBank];
  assign refCnt = bankCnt[!curBank];
  assign full   = (curCnt == CNT_W'(CAP));

  // parallel membership test against every occupied slot
  for (genvar j = 0; j < CAP; j++) begin : g_cmp
    assign hitVec[j] = (CNT_W'(j) < curCnt) && (bankMem[curBank][j] == accAddr);
  end
  assign hit     = |hitVec;
  assign doStore = ctl.recEn && !hit && !full;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankCnt[0] <= '0;
      bankCnt[1] <= '0;
      curBank    <= 1'b0;
    end else begin
      if (ctl.clearCur)   bankCnt[curBank] <= '0;
      else if (doStore)   bankCnt[curBank] <= curCnt + 1'b1;
      if (ctl.swapBanks)  curBank <= !curBank;
    end
  end

  always_ff @(posedge clk) begin
    if (doStore) bankMem[curBank][curCnt[IDX_W-1:0]] <= accAddr;
  end

  assign diffData = $signed({1'b0, bankMem[curBank][rdIdx[IDX_W-1:0]]})
                  - $signed({1'b0, bankMem[!curBank][rdIdx[IDX_W-1:0]]});

  assert_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    curCnt <= CNT_W'(CAP));

  assert_dedup_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.recEn && hit) |=> $stable(curCnt));

  assert_grow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.recEn && !hit && !full) |=> (curCnt == $past(curCnt) + 1'b1));
endmodule

// File: rtl/asd_ctrl.sv
module asd_ctrl
  import asd_pkg::*;
#(
  parameter int CAP   = 8,
  parameter int CNT_W = $clog2(CAP + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             taskStart,
  input  logic             taskStop,
  input  logic             accValid,
  input  logic             hit,
  input  logic             full,
  input  logic [CNT_W-1:0] curCnt,
  input  logic [CNT_W-1:0] refCnt,
  output dpCtl_t           ctl,
  output logic [CNT_W-1:0] rdIdx,
  output logic             diffValid,
  output logic             diffLast,
  output logic             lenMismatch,
  output logic             setOverflow
);
  asdState_t        state;
  logic             haveRef;
  logic [CNT_W-1:0] emitLen;

  assign emitLen   = (curCnt < refCnt) ? curCnt : refCnt;
  assign diffValid = (state == ST_EMIT);
  assign diffLast  = diffValid && (rdIdx == emitLen - 1'b1);

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_IDLE: ctl.clearCur  = taskStart;
      ST_REC:  begin
        ctl.recEn     = accValid && !taskStop;
        ctl.swapBanks = taskStop && !(haveRef && emitLen != '0);
      end
      ST_EMIT: ctl.swapBanks = diffLast;
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      haveRef     <= 1'b0;
      rdIdx       <= '0;
      lenMismatch <= 1'b0;
      setOverflow <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (taskStart) begin
          state       <= ST_REC;
          lenMismatch <= 1'b0;
          setOverflow <= 1'b0;
        end
        ST_REC: begin
          if (taskStop) begin
            lenMismatch <= haveRef && (curCnt != refCnt);
            haveRef     <= 1'b1;
            rdIdx       <= '0;
            state       <= (haveRef && emitLen != '0) ? ST_EMIT : ST_IDLE;
          end else if (accValid && !hit && full) begin
            setOverflow <= 1'b1;
          end
        end
        ST_EMIT: begin
          rdIdx <= rdIdx + 1'b1;
          if (diffLast) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ovf_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setOverflow) |-> $past(state == ST_REC));

  assert_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    diffLast |-> diffValid);

  assert_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    diffValid |-> haveRef);

  assert_mis_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (diffValid && $past(diffValid)) |-> $stable(lenMismatch));

  assert_span_R8: assert property (@(posedge clk) disable iff (!rstN)
    diffValid |-> (rdIdx < emitLen));
endmodule

// File: rtl/addr_set_diff.sv
module addr_set_diff
  import asd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CAP    = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  taskStart,
  input  logic                  taskStop,
  input  logic                  accValid,
  input  logic                  accWrite,
  input  logic [ADDR_W-1:0]     accAddr,
  output logic                  diffValid,
  output logic                  diffLast,
  output logic signed [ADDR_W:0] diffData,
  output logic                  lenMismatch,
  output logic                  setOverflow
);
  localparam int CNT_W = $clog2(CAP + 1);

  dpCtl_t           ctl;
  logic             hit, full;
  logic [CNT_W-1:0] curCnt, refCnt, rdIdx;
  logic             unusedAccWrite;

  // reads and writes are treated alike for set membership
  assign unusedAccWrite = accWrite;

  asd_ctrl #(.CAP(CAP), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .taskStart(taskStart), .taskStop(taskStop),
    .accValid(accValid), .hit(hit), .full(full), .curCnt(curCnt),
    .refCnt(refCnt), .ctl(ctl), .rdIdx(rdIdx), .diffValid(diffValid),
    .diffLast(diffLast), .lenMismatch(lenMismatch), .setOverflow(setOverflow)
  );

  asd_dpath #(.ADDR_W(ADDR_W), .CAP(CAP), .CNT_W(CNT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .accAddr(accAddr), .rdIdx(rdIdx),
    .hit(hit), .full(full), .curCnt(curCnt), .refCnt(refCnt),
    .diffData(diffData)
  );
endmodule

// File: tb/addr_set_diff_tb_top.sv
module addr_set_diff_tb_top;
  localparam int AW  = 32;
  localparam int CAP = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic taskStart = 1'b0, taskStop = 1'b0, accValid = 1'b0, accWrite = 1'b0;
  logic [AW-1:0] accAddr = '0;
  logic diffValid, diffLast, lenMismatch, setOverflow;
  logic signed [AW:0] diffData;

  always #4 clk = ~clk;  // 125 MHz

  addr_set_diff #(.ADDR_W(AW), .CAP(CAP)) dut_i (
    .clk(clk), .rstN(rstN), .taskStart(taskStart), .taskStop(taskStop),
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr),
    .diffValid(diffValid), .diffLast(diffLast), .diffData(diffData),
    .lenMismatch(lenMismatch), .setOverflow(setOverflow)
  );

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // bench model built from the requirements
  logic [AW-1:0] mCur [CAP];
  logic [AW-1:0] mRef [CAP];
  int  mCurN = 0, mRefN = 0;
  bit  mHaveRef = 0, mRec = 0, mOvf = 0;

  localparam logic [AW-1:0] TBL [4][8] = '{
    '{32'h10000, 32'h60000, 32'h8000000, 32'h7F00000, 32'hFE000, 0, 0, 0},
    '{32'h10020, 32'h60060, 32'h8000008, 32'h7F00040, 32'hFE060, 0, 0, 0},
    '{32'h10000, 32'h10000, 32'h60000, 32'h60000, 32'h8000000,
      32'h7F00000, 32'h10000, 32'hFE000},
    '{32'h20000, 32'h60000, 32'h8000000, 32'h7F00000, 32'hFE000,
      32'h300, 32'h400, 0}
  };
  localparam int TBL_N [4] = '{5, 5, 8, 7};
  localparam logic [7:0] TBL_WR [4] = '{8'h00, 8'h0A, 8'h42, 8'h10};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    taskStart = 1'b1;
    @(negedge clk);
    taskStart = 1'b0;
    if (!mRec) begin mRec = 1; mCurN = 0; mOvf = 0; end
  endtask

  task automatic access(input logic [AW-1:0] a, input logic wr);
    bit found = 0;
    accValid = 1'b1; accAddr = a; accWrite = wr;
    @(negedge clk);
    accValid = 1'b0;
    if (mRec) begin
      for (int k = 0; k < mCurN; k++) if (mCur[k] == a) found = 1;
      if (!found) begin
        if (mCurN < CAP) begin mCur[mCurN] = a; mCurN++; end
        else mOvf = 1;
      end
    end
  endtask

  task automatic stopAndCheck(input string tag);
    int n;
    bit expMis;
    logic signed [AW:0] expD;
    taskStop = 1'b1;
    @(negedge clk);
    taskStop = 1'b0;
    mRec = 0;
    n = mHaveRef ? ((mCurN < mRefN) ? mCurN : mRefN) : 0;
    expMis = mHaveRef && (mCurN != mRefN);
    chk(lenMismatch == expMis, "R8", {tag, " lenMismatch"}, 64'(lenMismatch), 64'(expMis));
    chk(setOverflow == mOvf, "R7", {tag, " setOverflow"}, 64'(setOverflow), 64'(mOvf));
    for (int i = 0; i < n; i++) begin
      expD = $signed({1'b0, mCur[i]}) - $signed({1'b0, mRef[i]});
      chk(diffValid == 1'b1, "R6", {tag, " diffValid"}, 64'(diffValid), 64'd1);
      chk(diffData == expD, "R4", {tag, " diffData"}, 64'(diffData), 64'(expD));
      chk(diffLast == (i == n - 1), "R6", {tag, " diffLast"}, 64'(diffLast), 64'(i == n - 1));
      @(negedge clk);
    end
    chk(diffValid == 1'b0, mHaveRef ? "R6" : "R5", {tag, " end of stream"}, 64'(diffValid), 64'd0);
    for (int k = 0; k < mCurN; k++) mRef[k] = mCur[k];
    mRefN = mCurN;
    mHaveRef = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk(diffValid == 0 && lenMismatch == 0 && setOverflow == 0, "R5", "reset state",
        {61'd0, diffValid, lenMismatch, setOverflow}, 64'd0);

    // table walk: R3/R4/R9 stride example, R2 dedup reads+writes, R8 longer set
    for (int r = 0; r < 4; r++) begin
      pulseStart();
      for (int a = 0; a < TBL_N[r]; a++) access(TBL[r][a], TBL_WR[r][a]);
      stopAndCheck($sformatf("R9 row%0d", r));
    end

    // R1: accesses while idle and on start/stop cycles are ignored
    access(32'hDEAD0, 1'b0);
    taskStart = 1'b1; accValid = 1'b1; accAddr = 32'hBEEF0;
    @(negedge clk);
    taskStart = 1'b0; accValid = 1'b0; mRec = 1; mCurN = 0; mOvf = 0;
    access(32'h20010, 1'b1);
    access(32'h60010, 1'b0);
    taskStop = 1'b1; accValid = 1'b1; accAddr = 32'hCAFE0;
    @(negedge clk);
    taskStop = 1'b0; accValid = 1'b0; mRec = 0;
    chk(lenMismatch == 1'b1, "R1", "window mismatch", 64'(lenMismatch), 64'd1);
    for (int i = 0; i < 2; i++) begin
      logic signed [AW:0] e;
      e = $signed({1'b0, mCur[i]}) - $signed({1'b0, mRef[i]});
      chk(diffValid && diffData == e && diffLast == (i == 1), "R1", "window element",
          64'(diffData), 64'(e));
      @(negedge clk);
    end
    chk(diffValid == 1'b0, "R1", "window stream length", 64'(diffValid), 64'd0);
    for (int k = 0; k < 2; k++) mRef[k] = mCur[k];
    mRefN = 2;

    // R10: start during recording does not clear the set
    pulseStart();
    access(32'h20000, 1'b0);
    pulseStart();
    access(32'h60000, 1'b1);
    access(32'h70000, 1'b0);
    stopAndCheck("R10 restart ignored");

    // R7: overflow past capacity, then cleared by the next start
    pulseStart();
    for (int a = 0; a < CAP + 2; a++) access(32'h1000 * (a + 1), a[0]);
    access(32'h1000, 1'b1);
    stopAndCheck("R7 overflow");
    pulseStart();
    chk(setOverflow == 1'b0, "R7", "cleared on start", 64'(setOverflow), 64'd0);
    stopAndCheck("R8 empty set");

    // R5: reset mid-sequence restores silent first instance
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mHaveRef = 0; mRec = 0; mRefN = 0;
    pulseStart();
    access(32'h500, 1'b0);
    stopAndCheck("R5 first after reset");
    pulseStart();
    access(32'h4F0, 1'b0);
    stopAndCheck("R4 negative after reset");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule